// File: doc/BRIEF.md
# Programmable-Width CRC Accelerator

This block computes a cyclic redundancy check over a stream of 32-bit words. Words are written into it over a simple register bus. Software programs a runtime polynomial of any width up to 32 bits, written left-justified. It then loads a justified seed into the result register and sets a control word. That control word enables the engine and chooses the input mirroring and the shift direction. After that, every word written to the data port is folded into the running remainder.

Each accepted word first passes through a mirroring stage. The stage can exchange the two halfwords, reverse the byte order and reverse the bits within each byte, in that order. A serial engine then consumes the mirrored word from bit 31 down to bit 0, one bit per clock.

A writer such as a DMA channel may issue words back to back. The bus ready signal stays low for the 32 cycles that a word occupies the engine, so the writer waits instead of losing data. Clearing the enable bit puts the block in an idle state in which data writes are dropped.

Top module: `crc_accel`

## Requirements
- R1: After reset, the control, polynomial and result registers read 0 and bus_ready is 1. The register offsets are: 0 control, 1 polynomial, 2 result/seed, 3 data port (write-only, reads 0).
- R2: The control register bits are: bit 0 enable, bit 1 LSB-first, bit 2 halfword swap, bit 3 byte reverse, bit 4 bit-in-byte reverse, and bit 5 busy (read-only). Bits 4:0 read back as written.
- R3: A data write while enable is 0 is ignored: the result register is unchanged and bus_ready stays 1.
- R4: A data write accepted while enabled holds bus_ready low for exactly 32 cycles.
- R5: A write presented while bus_ready is 0 is not accepted and changes no register.
- R6: The mirroring stage applies the halfword swap first, then the byte reverse (byte 0 and byte 3 exchange, byte 1 and byte 2 exchange), then the bit reverse within each byte.
- R7: In MSB-first mode, each input bit is XORed with remainder bit 31. The remainder shifts left and is XORed with the left-justified polynomial when the feedback is 1. An x-bit result occupies the x most significant bits.
- R8: In LSB-first mode, each input bit is XORed with remainder bit 0. The remainder shifts right and is XORed with the bit-reversed polynomial when the feedback is 1. An x-bit result occupies the x least significant bits.
- R9: While a word is being processed, the result register returns the remainder as of the last completed word.
- R10: The remainder accumulates across any number of consecutive data writes, including writes that are stalled back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register word offset |
| bus_wr | input | 1 | Write strobe, held until bus_ready |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| bus_ready | output | 1 | Write accepted when high |

## Verification
Two standard byte-wise checks are run with their mirror settings. The first is reflected CRC-32, using the byte and bit reverse in LSB-first mode. The second is a 16-bit CCITT check with no mirroring in MSB-first mode. Both show that the mirroring, the shift direction and the result placement combine correctly against algorithms written in an unrelated byte-oriented form.

Random multi-word messages under all eight mirroring combinations tell the three transforms apart, including the order in which they are applied. A reflected 16-bit run checks that the result lands in the low bits. Directed cases cover the disabled state, the exact stall length, a stalled write to another register, and reading the result mid-word.

// File: rtl/crc_accel_pkg.sv
package crc_accel_pkg;
   localparam logic [1:0] OFS_CTRL   = 2'd0;
   localparam logic [1:0] OFS_POLY   = 2'd1;
   localparam logic [1:0] OFS_RESULT = 2'd2;
   localparam logic [1:0] OFS_DATA   = 2'd3;

   typedef struct packed {
      logic bit_rev;
      logic byte_rev;
      logic swap_half;
      logic lsb_first;
      logic en;
   } ctrl_t;
endpackage

// File: rtl/crc_mirror.sv
module crc_mirror #(
   parameter int W = 32
) (
   input  logic         swap_half,
   input  logic         byte_rev,
   input  logic         bit_rev,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   localparam int NB = W / 8;
   localparam int HW = W / 2;

   logic [W-1:0] swapped, bytes_rev, bits_rev, s2;

   assign swapped = swap_half ? {din[HW-1:0], din[W-1:HW]} : din;

   for (genvar i = 0; i < NB; i++) begin : g_byte
      assign bytes_rev[8*i +: 8] = swapped[8*(NB-1-i) +: 8];
      for (genvar j = 0; j < 8; j++) begin : g_bit
         assign bits_rev[8*i+j] = s2[8*i+7-j];
      end
   end

   assign s2   = byte_rev ? bytes_rev : swapped;
   assign dout = bit_rev ? bits_rev : s2;
endmodule

// File: rtl/crc_engine.sv
module crc_engine #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         lsb_first,
   input  logic [W-1:0] poly,
   input  logic [W-1:0] seed,
   input  logic [W-1:0] word,
   output logic         busy,
   output logic         last,
   output logic [W-1:0] rem_next
);
   localparam int CW = $clog2(W);
   localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

   logic [W-1:0]  rem_q, sh_q, poly_rev;
   logic [CW-1:0] cnt_q;
   logic          fb;

   for (genvar i = 0; i < W; i++) begin : g_rev
      assign poly_rev[i] = poly[W-1-i];
   end

   always_comb begin
      if (lsb_first) begin
         fb       = rem_q[0] ^ sh_q[W-1];
         rem_next = (rem_q >> 1) ^ (fb ? poly_rev : '0);
      end else begin
         fb       = rem_q[W-1] ^ sh_q[W-1];
         rem_next = (rem_q << 1) ^ (fb ? poly : '0);
      end
   end

   assign last = busy && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         sh_q  <= '0;
         cnt_q <= '0;
         busy  <= 1'b0;
      end else if (start && !busy) begin
         rem_q <= seed;
         sh_q  <= word;
         cnt_q <= LAST_IDX;
         busy  <= 1'b1;
      end else if (busy) begin
         rem_q <= rem_next;
         sh_q  <= sh_q << 1;
         cnt_q <= cnt_q - 1'b1;
         if (cnt_q == '0) busy <= 1'b0;
      end
   end
endmodule

// File: rtl/crc_accel.sv
module crc_accel
   import crc_accel_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [1:0]   bus_addr,
   input  logic         bus_wr,
   input  logic [W-1:0] bus_wdata,
   output logic [W-1:0] bus_rdata,
   output logic         bus_ready
);
   if (W < 16 || (W % 16) != 0) begin : g_bad_w
      $error("crc_accel: W must be a multiple of 16");
   end

   ctrl_t        ctrl_q;
   logic [W-1:0] poly_q, result_q, mirrored, rem_next;
   logic         busy, last, wr_ok, start;

   assign bus_ready = !busy;
   assign wr_ok     = bus_wr && bus_ready;
   assign start     = wr_ok && (bus_addr == OFS_DATA) && ctrl_q.en;

   crc_mirror #(.W(W)) u_mirror (
      .swap_half (ctrl_q.swap_half),
      .byte_rev  (ctrl_q.byte_rev),
      .bit_rev   (ctrl_q.bit_rev),
      .din       (bus_wdata),
      .dout      (mirrored)
   );

   crc_engine #(.W(W)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .lsb_first (ctrl_q.lsb_first),
      .poly      (poly_q),
      .seed      (result_q),
      .word      (mirrored),
      .busy      (busy),
      .last      (last),
      .rem_next  (rem_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         poly_q   <= '0;
         result_q <= '0;
      end else begin
         if (last) result_q <= rem_next;
         if (wr_ok) begin
            case (bus_addr)
               OFS_CTRL:   ctrl_q   <= ctrl_t'(bus_wdata[4:0]);
               OFS_POLY:   poly_q   <= bus_wdata;
               OFS_RESULT: result_q <= bus_wdata;
               default:    ;
            endcase
         end
      end
   end

   always_comb begin
      case (bus_addr)
         OFS_CTRL:   bus_rdata = W'({busy, ctrl_q});
         OFS_POLY:   bus_rdata = poly_q;
         OFS_RESULT: bus_rdata = result_q;
         default:    bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/crc_accel_chk.sv
module crc_accel_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic [1:0]   bus_addr,
   input logic         bus_wr,
   input logic         bus_ready,
   input logic         en,
   input logic [W-1:0] result,
   input logic [W-1:0] poly
);
   localparam int CNT_W = $clog2(W) + 2;
   localparam logic [CNT_W-1:0] BUSY_LEN = CNT_W'(W);

   logic [CNT_W-1:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) low_cnt <= '0;
      else if (bus_ready) low_cnt <= '0;
      else low_cnt <= low_cnt + 1'b1;
   end

   a_r4_accept_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_ready && en && bus_addr == 2'd3) |=> !bus_ready);

   a_r4_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_ready) |-> (low_cnt == BUSY_LEN));

   a_r3_disabled_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_ready && !en && bus_addr == 2'd3) |=> bus_ready);

   a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_ready && $past(!bus_ready)) |-> $stable(result));

   a_r5_poly_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_ready && bus_wr) |=> $stable(poly));
endmodule

bind crc_accel crc_accel_chk #(.W(W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_ready (bus_ready),
   .en        (ctrl_q.en),
   .result    (result_q),
   .poly      (poly_q)
);

// File: tb/crc_accel_bench.sv
module crc_accel_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_ready;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   crc_accel u_crc_accel (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      while (!bus_ready) @(negedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wr = 1'b0;
      #1 d = bus_rdata;
   endtask

   task automatic wait_idle();
      while (!bus_ready) @(negedge clk);
   endtask

   function automatic logic [31:0] mirror(input logic [31:0] d, input bit sw, input bit by, input bit bi);
      logic [31:0] t = d;
      logic [31:0] u;
      if (sw) t = {t[15:0], t[31:16]};
      if (by) t = {t[7:0], t[15:8], t[23:16], t[31:24]};
      if (bi) begin
         for (int i = 0; i < 32; i++) u[i] = t[(i/8)*8 + 7 - (i%8)];
         t = u;
      end
      return t;
   endfunction

   function automatic logic [31:0] ref_word(input logic [31:0] rem, input logic [31:0] poly,
                                             input logic [31:0] w, input bit lsb);
      logic [31:0] pr;
      for (int i = 0; i < 32; i++) pr[i] = poly[31-i];
      for (int i = 31; i >= 0; i--) begin
         if (lsb) begin
            if (rem[0] ^ w[i]) rem = (rem >> 1) ^ pr; else rem = rem >> 1;
         end else begin
            if (rem[31] ^ w[i]) rem = (rem << 1) ^ poly; else rem = rem << 1;
         end
      end
      return rem;
   endfunction

   // Byte-wise reflected CRC (poly given reflected), bytes of a word taken low byte first
   function automatic logic [31:0] refl_bytes(input logic [31:0] c, input logic [31:0] rp, input logic [31:0] w);
      for (int b = 0; b < 4; b++) begin
         c = c ^ 32'(w[8*b +: 8]);
         for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ rp) : (c >> 1);
      end
      return c;
   endfunction

   // Byte-wise CRC-16-CCITT, bytes taken high byte first
   function automatic logic [15:0] ccitt_bytes(input logic [15:0] c, input logic [31:0] w);
      for (int b = 3; b >= 0; b--) begin
         c = c ^ {w[8*b +: 8], 8'h00};
         for (int k = 0; k < 8; k++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
      end
      return c;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d, exp, seed, w;
      int n;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(2'd0, d); chk("R1 ctrl", d, 0);
      rd(2'd1, d); chk("R1 poly", d, 0);
      rd(2'd2, d); chk("R1 result", d, 0);
      rd(2'd3, d); chk("R1 data reads 0", d, 0);
      chk("R1 ready", 32'(bus_ready), 1);

      // R2 control readback
      wr(2'd0, 32'h1E);
      rd(2'd0, d); chk("R2 ctrl readback", d, 32'h1E);

      // R3 disabled write ignored
      wr(2'd1, 32'h04C11DB7);
      wr(2'd2, 32'h12345678);
      wr(2'd3, 32'hDEADBEEF);
      chk("R3 ready stays high", 32'(bus_ready), 1);
      rd(2'd2, d); chk("R3 result unchanged", d, 32'h12345678);

      // R4 busy length, R9 read mid-word, R2 busy bit
      wr(2'd0, 32'h01);
      wr(2'd3, 32'hA5A5A5A5);
      rd(2'd2, d); chk("R9 result holds seed while busy", d, 32'h12345678);
      rd(2'd0, d); chk("R2 busy bit", d, 32'h21);
      n = 2;
      while (!bus_ready) begin n++; @(negedge clk); end
      chk("R4 busy cycles", 32'(n), 32);
      rd(2'd2, d);
      chk("R7 single word", d, ref_word(32'h12345678, 32'h04C11DB7, 32'hA5A5A5A5, 0));

      // R5 stalled write to poly has no effect
      wr(2'd3, 32'h0F0F0F0F);
      @(negedge clk); bus_addr = 2'd1; bus_wdata = 32'hFFFF0000; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0;
      wait_idle();
      rd(2'd1, d); chk("R5 poly unchanged", d, 32'h04C11DB7);

      // R7 R8 R10 CRC-32 reflected vs byte-wise reference
      wr(2'd0, 32'h1B);           // en, lsb, byte_rev, bit_rev
      wr(2'd2, 32'hFFFFFFFF);
      exp = 32'hFFFFFFFF;
      for (int k = 0; k < 5; k++) begin
         w = $urandom; wr(2'd3, w); exp = refl_bytes(exp, 32'hEDB88320, w);
      end
      wait_idle();
      rd(2'd2, d); chk("R8 R10 CRC-32 reflected", d, exp);

      // R7 CRC-16-CCITT MSB first, result in upper bits
      wr(2'd0, 32'h01);
      wr(2'd1, 32'h10210000);
      wr(2'd2, 32'hFFFF0000);
      exp = 32'h0000FFFF;
      for (int k = 0; k < 4; k++) begin
         w = $urandom; wr(2'd3, w); exp[15:0] = ccitt_bytes(exp[15:0], w);
      end
      wait_idle();
      rd(2'd2, d); chk("R7 CRC-16 in upper bits", d, {exp[15:0], 16'h0});

      // R8 reflected 16-bit, result in lower bits
      wr(2'd0, 32'h1B);
      wr(2'd2, 32'h0000FFFF);
      exp = 32'h0000FFFF;
      for (int k = 0; k < 3; k++) begin
         w = $urandom; wr(2'd3, w); exp = refl_bytes(exp, 32'h00008408, w);
      end
      wait_idle();
      rd(2'd2, d); chk("R8 16-bit in lower bits", d, exp);

      // R6 all mirror combinations, both directions, random multi-word
      wr(2'd1, 32'h04C11DB7);
      for (int c = 0; c < 16; c++) begin
         bit sw = c[0], by = c[1], bi = c[2], lsb = c[3];
         wr(2'd0, {27'd0, bi, by, sw, lsb, 1'b1});
         seed = $urandom;
         wr(2'd2, seed);
         exp = seed;
         for (int k = 0; k < 3; k++) begin
            w = $urandom; wr(2'd3, w);
            exp = ref_word(exp, 32'h04C11DB7, mirror(w, sw, by, bi), lsb);
         end
         wait_idle();
         rd(2'd2, d); chk($sformatf("R6 R10 mirror combo %0d", c), d, exp);
      end

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule